// File: doc/BRIEF.md
# ACPI Power-Management Timer and Event Block

This block keeps a free-running tick count that advances once per clock cycle in which a tick enable is high. The tick enable represents the fixed power-management timer frequency. Software sees the low `TMR_W` bits of that count as a read-only counter. Alongside the counter, the block keeps a deadline that sits on a half-range boundary of the count. When the count reaches the deadline, the timer status flag is raised.

Three further status flags are set by single-cycle pulses from outside event sources: a real-time-clock alarm, the power button and a global-lock release. An enable register selects which flags may drive a level-sensitive system-control interrupt line. The status register is write-one-to-clear. When software clears a timer flag that was set, the deadline moves forward to the next half-range boundary above the current count. The register port is synchronous for writes and combinational for reads. A status read shows the deadline check made in that same cycle.

Top module: `pm_timer_evt`

## Requirements
- R1: Offset 0x08 reads the low `TMR_W` bits of the tick count, with all higher bits reading zero. The count goes up by one at each clock edge where `tick_i` is high and holds at every other edge.
- R2: The timer status flag (bit 0) is set whenever the tick count is at or above the stored deadline. This check runs every cycle, with or without a register access.
- R3: A read at offset 0x00 returns the status bits 0, 5, 8 and 10. Bit 0 already includes the deadline check made in the same cycle. All other bits read zero.
- R4: Writing 1 to a status bit at offset 0x00 clears that bit. Writing 0 leaves it unchanged.
- R5: A status write that clears a set timer flag moves the deadline to the smallest multiple of 2^(`TMR_W`-1) that is strictly above the count in that cycle. Writing 1 to bit 0 while the flag is clear leaves the deadline where it is.
- R6: A pulse on `rtc_evt_i` sets status bit 10, `pwrbtn_evt_i` sets bit 8, and `gbl_evt_i` sets bit 5. If a pulse and a software clear of the same bit fall in the same cycle, the pulse wins.
- R7: Offset 0x02 is a 16-bit enable register that can be both written and read.
- R8: `sci_o` is high exactly when some status bit among 0, 5, 8 and 10 is set and its enable bit is also set. The status used is the registered status. Enable bits outside this set have no effect.
- R9: After reset the deadline is zero, the count is zero and the enable register is zero. As a result, status bit 0 reads 1 from the first cycle and `sci_o` is low.
- R10: Reads at offsets other than 0x00, 0x02 and 0x08 return zero. Writes to those offsets change no register.
- R11: When the deadline is reached in the same cycle that software writes 1 to status bit 0, the clear wins: the flag ends up 0 and the deadline moves to the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer-frequency tick enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| rtc_evt_i | input | 1 | Real-time-clock alarm set pulse |
| pwrbtn_evt_i | input | 1 | Power-button set pulse |
| gbl_evt_i | input | 1 | Global-lock release set pulse |
| sci_o | output | 1 | Level-sensitive system-control interrupt |

## Verification
The collision that matters is a deadline expiry and a write-one-to-clear of the timer flag landing in the same cycle. The same question also arises for an external event pulse against a clear of its own bit. The bench runs the count up to exactly the deadline and issues the clear in that cycle. It then checks three things: the read in the write cycle shows the raised flag, the next read shows it cleared, and the flag rises again only at the following boundary. A long mixed sweep with a narrow counter crosses many boundaries. It lands writes, pulses and ticks in every combination, and each result is judged against an arithmetic model of the count, deadline and status.

// File: rtl/pm_tmr_pkg.sv
package pm_tmr_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned BIT_TMR    = 0;
  localparam int unsigned BIT_GBL    = 5;
  localparam int unsigned BIT_PWRBTN = 8;
  localparam int unsigned BIT_RTC    = 10;
  localparam logic [REG_W-1:0] STS_IMPL =
    (REG_W'(1) << BIT_TMR) | (REG_W'(1) << BIT_GBL) |
    (REG_W'(1) << BIT_PWRBTN) | (REG_W'(1) << BIT_RTC);
  localparam int unsigned OFF_STS = 'h0;
  localparam int unsigned OFF_EN  = 'h2;
  localparam int unsigned OFF_CNT = 'h8;
endpackage

// File: rtl/pm_tick_tracker.sv
module pm_tick_tracker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rearm_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam int unsigned      HALF_BIT   = TMR_W - 1;
  localparam logic [CNT_W-1:0] ONE        = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] STEP       = ONE << HALF_BIT;
  localparam logic [CNT_W-1:0] ALIGN_MASK = ~(STEP - ONE);

  logic [CNT_W-1:0] cnt_q, deadline_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      deadline_q <= '0;
    end else begin
      cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, tick_i};
      // next boundary strictly above the present count
      if (rearm_i) deadline_q <= (cnt_q + STEP) & ALIGN_MASK;
    end
  end

  assign cnt_o     = cnt_q[TMR_W-1:0];
  assign expired_o = (cnt_q >= deadline_q);

  // R1
  tick_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + ONE);
  // R1
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R5
  rearm_ahead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (deadline_q > $past(cnt_q)) && ((deadline_q & ~ALIGN_MASK) == '0));
  // R5
  deadline_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rearm_i |=> $stable(deadline_q));
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
  import pm_tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expired_i,
  input  logic [REG_W-1:0] evt_set_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] clr_mask_i,
  input  logic             en_we_i,
  input  logic [REG_W-1:0] en_wdata_i,
  output logic [REG_W-1:0] sts_view_o,
  output logic [REG_W-1:0] en_o,
  output logic             rearm_o,
  output logic             sci_o
);
  logic [REG_W-1:0] sts_q, en_q, tmr_vec, clr_vec, sts_d;

  always_comb begin
    tmr_vec          = '0;
    tmr_vec[BIT_TMR] = expired_i;
    sts_view_o       = (sts_q | tmr_vec) & STS_IMPL;
    clr_vec          = clr_we_i ? clr_mask_i : '0;
    // pulses after the clear: a same-cycle event survives
    sts_d            = ((sts_view_o & ~clr_vec) | evt_set_i) & STS_IMPL;
  end

  assign rearm_o = clr_we_i & sts_view_o[BIT_TMR] & clr_mask_i[BIT_TMR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign en_o  = en_q;
  assign sci_o = |(sts_q & en_q & STS_IMPL);

  // R6
  rtc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_set_i[BIT_RTC] |=> sts_q[BIT_RTC]);
  // R4
  gbl_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_mask_i[BIT_GBL] && !evt_set_i[BIT_GBL] |=> !sts_q[BIT_GBL]);
  // R4
  pwrbtn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q[BIT_PWRBTN] && !(clr_we_i && clr_mask_i[BIT_PWRBTN]) |=> sts_q[BIT_PWRBTN]);
  // R11
  tmr_clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_mask_i[BIT_TMR] && !evt_set_i[BIT_TMR] |=> !sts_q[BIT_TMR]);
  // R8
  sci_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !sci_o);
endmodule

// File: rtl/pm_timer_evt.sv
module pm_timer_evt
  import pm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TMR_W  = 24,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rtc_evt_i,
  input  logic              pwrbtn_evt_i,
  input  logic              gbl_evt_i,
  output logic              sci_o
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_CNT);

  logic [TMR_W-1:0] cnt;
  logic             expired, rearm;
  logic [REG_W-1:0] sts_view, en, evt_set;
  logic             sel_sts, sel_en, sel_cnt;

  assign sel_sts = (addr_i == A_STS);
  assign sel_en  = (addr_i == A_EN);
  assign sel_cnt = (addr_i == A_CNT);

  always_comb begin
    evt_set             = '0;
    evt_set[BIT_RTC]    = rtc_evt_i;
    evt_set[BIT_PWRBTN] = pwrbtn_evt_i;
    evt_set[BIT_GBL]    = gbl_evt_i;
  end

  pm_tick_tracker #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .rearm_i  (rearm),
    .cnt_o    (cnt),
    .expired_o(expired)
  );

  pm_evt_status u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expired_i (expired),
    .evt_set_i (evt_set),
    .clr_we_i  (wr_en_i & sel_sts),
    .clr_mask_i(wdata_i[REG_W-1:0]),
    .en_we_i   (wr_en_i & sel_en),
    .en_wdata_i(wdata_i[REG_W-1:0]),
    .sts_view_o(sts_view),
    .en_o      (en),
    .rearm_o   (rearm),
    .sci_o     (sci_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_sts)      rdata_o[REG_W-1:0] = sts_view;
    else if (sel_en)  rdata_o[REG_W-1:0] = en;
    else if (sel_cnt) rdata_o[TMR_W-1:0] = cnt;
  end

  // R9
  reset_tmr_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> sel_sts == 1'b0 || rdata_o[BIT_TMR]);
endmodule

// File: tb/pm_timer_evt_tb_top.sv
`timescale 1ns/1ps
module pm_timer_evt_tb_top;
  localparam int TMR_W = 6;
  localparam int HALF  = 1 << (TMR_W - 1);
  localparam logic [15:0] IMPL = 16'h0521;

  logic        clk = 0, rst_ni = 0;
  logic        tick = 0, wr = 0, rtc = 0, pwr = 0, gbl = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        sci;

  int vectors = 0, fails = 0;
  int cnt_m, dl_m;
  logic [15:0] sts_m, en_m;

  always #4 clk = ~clk;

  pm_timer_evt #(.TMR_W(TMR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rtc_evt_i(rtc), .pwrbtn_evt_i(pwr),
    .gbl_evt_i(gbl), .sci_o(sci)
  );

  task automatic step(input logic tk, input logic w, input int ad,
                      input logic [31:0] wd, input logic [2:0] ev, input string tag);
    logic [15:0] view, clr, evb;
    logic [31:0] exp_rd;
    logic        exp_sci, expd;
    @(negedge clk);
    tick = tk; wr = w; addr = 4'(ad); wdata = wd;
    rtc = ev[0]; pwr = ev[1]; gbl = ev[2];
    #1;
    expd = (cnt_m >= dl_m);
    view = (sts_m | {15'b0, expd}) & IMPL;
    if (ad == 0)      exp_rd = {16'b0, view};
    else if (ad == 2) exp_rd = {16'b0, en_m};
    else if (ad == 8) exp_rd = 32'(cnt_m % (1 << TMR_W));
    else              exp_rd = 32'h0;
    exp_sci = |(sts_m & en_m & IMPL);
    vectors++;
    if (rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s rdata addr=%0h actual=%h expected=%h", tag, ad, rdata, exp_rd);
    end
    vectors++;
    if (sci !== exp_sci) begin
      fails++;
      $display("FAIL R8 sci_o actual=%b expected=%b (%s)", sci, exp_sci, tag);
    end
    @(posedge clk);
    clr = (w && ad == 0) ? wd[15:0] : 16'h0;
    evb = 16'h0; evb[10] = ev[0]; evb[8] = ev[1]; evb[5] = ev[2];
    if (w && ad == 0 && view[0] && wd[0]) dl_m = ((cnt_m + HALF) / HALF) * HALF;
    sts_m = ((view & ~clr) | evb) & IMPL;
    if (w && ad == 2) en_m = wd[15:0];
    if (tk) cnt_m++;
  endtask

  function automatic string tag_of(input int ad);
    if (ad == 0) return "R3";
    if (ad == 2) return "R7";
    if (ad == 8) return "R1";
    return "R10";
  endfunction

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired before the run ended");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cnt_m = 0; dl_m = 0; sts_m = 0; en_m = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R9: deadline 0 already reached, enable 0, count 0
    step(0, 0, 0, 0, 3'b000, "R9");
    step(0, 0, 8, 0, 3'b000, "R9");
    step(0, 0, 2, 0, 3'b000, "R9");
    // R5: clear set flag rearms to next boundary
    step(1, 1, 0, 32'h1, 3'b000, "R5");
    step(1, 1, 0, 32'h1, 3'b000, "R5"); // flag clear now: no rearm
    step(0, 1, 2, 32'hFFFF_0001, 3'b000, "R7");
    // R2: run across the boundary, flag and sci appear without access
    while (cnt_m < dl_m + 2) step(1, 0, 8, 0, 3'b000, "R2");
    step(0, 0, 0, 0, 3'b000, "R2");
    // R11: clear in exactly the expiry cycle
    step(1, 1, 0, 32'h1, 3'b000, "R11");
    while (cnt_m < dl_m) step(1, 0, 8, 0, 3'b000, "R2");
    step(1, 1, 0, 32'h1, 3'b000, "R11");
    step(0, 0, 0, 0, 3'b000, "R11");
    // R6: event pulses, and pulse vs clear of same bit
    step(0, 1, 2, 32'h0521, 3'b111, "R6");
    step(0, 0, 0, 0, 3'b000, "R6");
    step(0, 1, 0, 32'h0520, 3'b001, "R6");
    step(0, 0, 0, 0, 3'b000, "R6");
    // R4: zeros leave bits, ones clear only their bit
    step(0, 0, 0, 0, 3'b110, "R4");
    step(0, 1, 0, 32'h0, 3'b000, "R4");
    step(0, 1, 0, 32'h20, 3'b000, "R4");
    step(0, 0, 0, 0, 3'b000, "R4");
    // R8: unimplemented enable bits do nothing
    step(0, 1, 2, 32'hFADE, 3'b000, "R8");
    // R10: unmapped writes and a full read sweep
    step(0, 1, 4, 32'hFFFF_FFFF, 3'b000, "R10");
    step(0, 1, 15, 32'hFFFF_FFFF, 3'b000, "R10");
    for (int a = 0; a < 16; a++) step(1, 0, a, 0, 3'b000, tag_of(a));
    // mixed sweep across many boundaries
    for (int i = 0; i < 4000; i++) begin
      int sel, ad;
      logic w;
      logic [2:0] ev;
      sel = int'($urandom_range(0, 4));
      ad  = (sel == 0) ? 0 : (sel == 1) ? 2 : (sel == 2) ? 8 : (sel == 3) ? 6 : 0;
      w   = ($urandom_range(0, 7) == 0);
      ev  = 3'b000;
      if ($urandom_range(0, 15) == 0) ev[$urandom_range(0, 2)] = 1'b1;
      step(logic'($urandom_range(0, 3) != 0), w, ad, $urandom, ev, tag_of(ad));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule